// File: doc/BRIEF.md
# Storage Key Protection Checker

This block guards a real storage space that is split into 2,048-byte blocks. Each block owns a small tag: a 4-bit access key, a fetch-protect flag, a referenced flag and a changed flag. Every storage request (address, direction, requester key) is judged against the tag of the block it falls in. The block answers with grant or violation one cycle later and, when the access is allowed, records the use by setting the referenced flag, plus the changed flag for a store.

A separate maintenance port lets privileged software write a whole tag, read a tag back, or read a tag while clearing its referenced flag in the same cycle. A low-address guard, when switched on, refuses every store into the first 512 bytes, whatever the requester key. The tag table covers a configurable number of blocks; requests beyond that reach are refused.

Top module: `stor_key_guard`

## Requirements
- R1: The block number of a request is `acc_addr[20:11]` with default parameters (2,048-byte blocks); two addresses differing only in bits 10..0 select the same tag.
- R2: A request whose address lies beyond the table's reach (any of `acc_addr[23:21]` set by default) is answered with a violation and changes no tag.
- R3: A store is granted only when the requester key equals the block key (or R5 applies); a refused store leaves the tag unchanged.
- R4: A fetch from a block whose fetch-protect flag is clear is always granted; with the flag set, the fetch is granted only when the keys match (or R5 applies).
- R5: A requester key of zero matches every block key, but does not override R2 or R7.
- R6: A granted fetch sets the referenced flag; a granted store sets both the referenced and changed flags; a violation changes neither.
- R7: With `lap_en` high, every store to an address below 512 is refused; fetches are not affected.
- R8: Tag layout on `op_wdata`/`op_rdata` is key in bits 6..3, fetch-protect in bit 2, referenced in bit 1, changed in bit 0. `op_code` 0 (write tag) replaces the whole tag of block `op_blk`.
- R9: `op_code` 1 (read tag) and the reserved code 3 change nothing; for every operation `op_rdata` shows the tag as it was before that operation, with `op_done` high, one cycle after `op_valid`.
- R10: `op_code` 2 (read and clear reference) returns the old tag and clears only the referenced flag, keeping the changed flag and the key.
- R11: When `op_valid` and `acc_valid` are high together, the operation is carried out and the access is dropped: no `acc_done`, no tag update from it.
- R12: After reset all outputs are low and every tag is zero.
- R13: `acc_done` is high exactly one cycle after an accepted request, with exactly one of `acc_grant`/`acc_viol` high; both are low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lap_en | input | 1 | Low-address store guard enable |
| acc_valid | input | 1 | Storage request present |
| acc_write | input | 1 | 1 = store, 0 = fetch |
| acc_addr | input | 24 | Real byte address |
| acc_key | input | 4 | Requester key |
| acc_done | output | 1 | Judgement available |
| acc_grant | output | 1 | Request allowed |
| acc_viol | output | 1 | Request refused |
| op_valid | input | 1 | Maintenance operation present |
| op_code | input | 2 | 0 write tag, 1 read tag, 2 read and clear reference, 3 reserved |
| op_blk | input | 10 | Block number for the operation |
| op_wdata | input | 7 | Tag to write |
| op_done | output | 1 | Operation completed |
| op_rdata | output | 7 | Tag before the operation |

## Verification
The checker watches, on every cycle, the response timing and exclusivity of grant and violation, the priority of maintenance operations over accesses, the refusal of out-of-reach addresses and of low-address stores under the guard, and that a zero-key fetch within reach is always granted. Whether a key match or mismatch is judged correctly, and how the referenced and changed flags evolve, depends on the stored tag history, so only the bench's scenarios show it: its reference model tracks every tag and compares every output each clock, and read-back operations expose the flags after each access.

// File: rtl/skg_pkg.sv
package skg_pkg;
   localparam int TAG_W = 7;
   localparam int KEY_W = 4;

   typedef struct packed {
      logic [KEY_W-1:0] key;
      logic             fprot;
      logic             refd;
      logic             chgd;
   } blk_tag_t;

   typedef enum logic [1:0] {
      OP_SET       = 2'd0,
      OP_INSERT    = 2'd1,
      OP_RESET_REF = 2'd2,
      OP_SPARE     = 2'd3
   } tag_op_e;
endpackage

// File: rtl/skg_key_table.sv
module skg_key_table
   import skg_pkg::*;
#(
   parameter int IDX_W          = 10,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_a_idx,
   output blk_tag_t         rd_a_tag,
   input  logic [IDX_W-1:0] rd_b_idx,
   output blk_tag_t         rd_b_tag,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  blk_tag_t         wr_tag
);
   localparam int DEPTH = 1 << IDX_W;

   blk_tag_t mem [DEPTH];

   assign rd_a_tag = mem[rd_a_idx];
   assign rd_b_tag = mem[rd_b_idx];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (wr_en) begin
               mem[wr_idx] <= wr_tag;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (wr_en) mem[wr_idx] <= wr_tag;
         end
      end
   endgenerate
endmodule

// File: rtl/skg_access_judge.sv
module skg_access_judge
   import skg_pkg::*;
#(
   parameter int ADDR_W        = 24,
   parameter int BLK_SHIFT     = 11,
   parameter int IDX_W         = 10,
   parameter int LOW_LIMIT     = 512,
   parameter bit MASTER_KEY_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_store,
   input  logic [KEY_W-1:0]  req_key,
   input  logic              lap_en,
   input  blk_tag_t          cur_tag,
   output logic [IDX_W-1:0]  blk_idx,
   output logic              grant,
   output blk_tag_t          next_tag
);
   localparam int REACH = BLK_SHIFT + IDX_W;
   localparam logic [ADDR_W-1:0] LOW_BOUND = ADDR_W'(LOW_LIMIT);

   logic in_reach;
   logic key_hit;
   logic low_zone;

   assign blk_idx  = addr[BLK_SHIFT +: IDX_W];
   assign low_zone = addr < LOW_BOUND;

   generate
      if (REACH < ADDR_W) begin : g_reach
         assign in_reach = ~|addr[ADDR_W-1:REACH];
      end else begin : g_full
         assign in_reach = 1'b1;
      end

      if (MASTER_KEY_EN) begin : g_master
         assign key_hit = (req_key == '0) || (req_key == cur_tag.key);
      end else begin : g_strict
         assign key_hit = (req_key == cur_tag.key);
      end
   endgenerate

   always_comb begin
      if (is_store) begin
         grant = in_reach && key_hit && !(lap_en && low_zone);
      end else begin
         grant = in_reach && (!cur_tag.fprot || key_hit);
      end
      next_tag      = cur_tag;
      next_tag.refd = cur_tag.refd | grant;
      next_tag.chgd = cur_tag.chgd | (grant & is_store);
   end
endmodule

// File: rtl/skg_op_unit.sv
module skg_op_unit
   import skg_pkg::*;
(
   input  logic       op_valid,
   input  logic [1:0] op_code,
   input  blk_tag_t   op_wtag,
   input  blk_tag_t   cur_tag,
   output logic       wr_en,
   output blk_tag_t   wr_tag
);
   tag_op_e code;
   assign code = tag_op_e'(op_code);

   always_comb begin
      wr_en  = 1'b0;
      wr_tag = cur_tag;
      if (op_valid) begin
         unique case (code)
            OP_SET: begin
               wr_en  = 1'b1;
               wr_tag = op_wtag;
            end
            OP_RESET_REF: begin
               wr_en       = 1'b1;
               wr_tag.refd = 1'b0;
            end
            OP_INSERT, OP_SPARE: begin
               wr_en = 1'b0;
            end
            default: wr_en = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/stor_key_guard.sv
module stor_key_guard
   import skg_pkg::*;
#(
   parameter int ADDR_W         = 24,
   parameter int BLK_SHIFT      = 11,
   parameter int TBL_BLKS       = 1024,
   parameter int LOW_LIMIT      = 512,
   parameter bit MASTER_KEY_EN  = 1'b1,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int IDX_W         = $clog2(TBL_BLKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lap_en,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [KEY_W-1:0]  acc_key,
   output logic              acc_done,
   output logic              acc_grant,
   output logic              acc_viol,
   input  logic              op_valid,
   input  logic [1:0]        op_code,
   input  logic [IDX_W-1:0]  op_blk,
   input  logic [TAG_W-1:0]  op_wdata,
   output logic              op_done,
   output logic [TAG_W-1:0]  op_rdata
);
   generate
      if (TBL_BLKS < 2 || (1 << IDX_W) != TBL_BLKS) begin : g_bad_depth
         $error("TBL_BLKS must be a power of two of at least 2");
      end
      if (BLK_SHIFT + IDX_W > ADDR_W) begin : g_bad_reach
         $error("table reach exceeds the address width");
      end
      if (LOW_LIMIT < 0 || LOW_LIMIT > (1 << BLK_SHIFT)) begin : g_bad_low
         $error("low guard window must lie within block zero");
      end
   endgenerate

   blk_tag_t         acc_tag, op_tag, acc_next, op_wr_tag, wr_tag;
   logic [IDX_W-1:0] acc_idx, wr_idx;
   logic             acc_ok, op_wr_en, wr_en, acc_take;

   assign acc_take = acc_valid && !op_valid;

   skg_key_table #(
      .IDX_W          (IDX_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_idx (acc_idx),
      .rd_a_tag (acc_tag),
      .rd_b_idx (op_blk),
      .rd_b_tag (op_tag),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_tag   (wr_tag)
   );

   skg_access_judge #(
      .ADDR_W        (ADDR_W),
      .BLK_SHIFT     (BLK_SHIFT),
      .IDX_W         (IDX_W),
      .LOW_LIMIT     (LOW_LIMIT),
      .MASTER_KEY_EN (MASTER_KEY_EN)
   ) u_judge (
      .addr     (acc_addr),
      .is_store (acc_write),
      .req_key  (acc_key),
      .lap_en   (lap_en),
      .cur_tag  (acc_tag),
      .blk_idx  (acc_idx),
      .grant    (acc_ok),
      .next_tag (acc_next)
   );

   skg_op_unit u_ops (
      .op_valid (op_valid),
      .op_code  (op_code),
      .op_wtag  (blk_tag_t'(op_wdata)),
      .cur_tag  (op_tag),
      .wr_en    (op_wr_en),
      .wr_tag   (op_wr_tag)
   );

   always_comb begin
      if (op_valid) begin
         wr_en  = op_wr_en;
         wr_idx = op_blk;
         wr_tag = op_wr_tag;
      end else begin
         wr_en  = acc_valid && acc_ok;
         wr_idx = acc_idx;
         wr_tag = acc_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_done  <= 1'b0;
         acc_grant <= 1'b0;
         acc_viol  <= 1'b0;
         op_done   <= 1'b0;
         op_rdata  <= '0;
      end else begin
         acc_done  <= acc_take;
         acc_grant <= acc_take && acc_ok;
         acc_viol  <= acc_take && !acc_ok;
         op_done   <= op_valid;
         op_rdata  <= op_valid ? TAG_W'(op_tag) : '0;
      end
   end
endmodule

// File: rtl/skg_checker.sv
module skg_checker #(
   parameter int ADDR_W    = 24,
   parameter int REACH     = 21,
   parameter int LOW_LIMIT = 512
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lap_en,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [3:0]        acc_key,
   input logic              acc_done,
   input logic              acc_grant,
   input logic              acc_viol,
   input logic              op_valid,
   input logic              op_done
);
   logic beyond;
   assign beyond = (acc_addr >> REACH) != '0;

   p_one_verdict_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_grant || acc_viol) == acc_done && !(acc_grant && acc_viol));

   p_answer_next_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !op_valid) |=> acc_done);

   p_quiet_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && !op_valid) |=> !acc_done);

   p_op_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> (op_done && !acc_done));

   p_low_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !op_valid && acc_write && lap_en && acc_addr < ADDR_W'(LOW_LIMIT))
      |=> acc_viol);

   p_reach_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !op_valid && beyond) |=> acc_viol);

   p_master_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !op_valid && !acc_write && acc_key == 4'd0 && !beyond) |=> acc_grant);
endmodule

bind stor_key_guard skg_checker #(
   .ADDR_W    (ADDR_W),
   .REACH     (BLK_SHIFT + IDX_W),
   .LOW_LIMIT (LOW_LIMIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lap_en    (lap_en),
   .acc_valid (acc_valid),
   .acc_write (acc_write),
   .acc_addr  (acc_addr),
   .acc_key   (acc_key),
   .acc_done  (acc_done),
   .acc_grant (acc_grant),
   .acc_viol  (acc_viol),
   .op_valid  (op_valid),
   .op_done   (op_done)
);

// File: tb/stor_key_guard_test.sv
`timescale 1ns/1ps
module stor_key_guard_test;
   localparam real HALF = 2.5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lap_en = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [23:0] acc_addr = '0;
   logic [3:0]  acc_key = '0;
   logic        acc_done, acc_grant, acc_viol;
   logic        op_valid = 1'b0;
   logic [1:0]  op_code = '0;
   logic [9:0]  op_blk = '0;
   logic [6:0]  op_wdata = '0;
   logic        op_done;
   logic [6:0]  op_rdata;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   logic [6:0] mtbl [1024];
   logic e_done, e_grant, e_viol, e_opd;
   logic [6:0] e_rd;

   always #HALF clk = ~clk;

   stor_key_guard uut (
      .clk(clk), .rst_n(rst_n), .lap_en(lap_en),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr), .acc_key(acc_key),
      .acc_done(acc_done), .acc_grant(acc_grant), .acc_viol(acc_viol),
      .op_valid(op_valid), .op_code(op_code), .op_blk(op_blk), .op_wdata(op_wdata),
      .op_done(op_done), .op_rdata(op_rdata)
   );

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(2.0 * HALF * 200000);
      fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   // Behavioural model: computes the expected response and updates the tag copy.
   task automatic model(input bit av, input bit aw, input int unsigned aa, input int ak,
                        input bit ov, input int oc, input int ob, input int owd, input bit lap);
      e_done = 0; e_grant = 0; e_viol = 0; e_opd = 0; e_rd = '0;
      if (ov) begin
         e_opd = 1;
         e_rd  = mtbl[ob];
         if (oc == 0) mtbl[ob] = 7'(owd);
         else if (oc == 2) mtbl[ob] = mtbl[ob] & 7'b1111101;
      end else if (av) begin
         int  b  = int'((aa >> 11) & 1023);
         bit  inr = aa < (1 << 21);
         logic [6:0] t = mtbl[b];
         bit  km = (ak == 0) || (ak == int'(t[6:3]));
         bit  g;
         if (aw) g = inr && km && !(lap && aa < 512);
         else    g = inr && (!t[2] || km);
         e_done = 1; e_grant = g; e_viol = !g;
         if (g) begin
            t[1] = 1'b1;
            if (aw) t[0] = 1'b1;
            mtbl[b] = t;
         end
      end
   endtask

   task automatic step(input bit av, input bit aw, input int unsigned aa, input int ak,
                       input bit ov, input int oc, input int ob, input int owd,
                       input bit lap, input string tag);
      @(negedge clk);
      acc_valid = av; acc_write = aw; acc_addr = 24'(aa); acc_key = 4'(ak);
      op_valid = ov; op_code = 2'(oc); op_blk = 10'(ob); op_wdata = 7'(owd);
      lap_en = lap;
      model(av, aw, aa, ak, ov, oc, ob, owd, lap);
      @(posedge clk);
      #1;
      checks++;
      if ({acc_done, acc_grant, acc_viol} !== {e_done, e_grant, e_viol}) begin
         fails++;
         $display("FAIL %s access done/grant/viol actual %b%b%b expected %b%b%b",
                  tag, acc_done, acc_grant, acc_viol, e_done, e_grant, e_viol);
      end
      checks++;
      if ({op_done, op_rdata} !== {e_opd, e_rd}) begin
         fails++;
         $display("FAIL %s op done/rdata actual %b/%h expected %b/%h",
                  tag, op_done, op_rdata, e_opd, e_rd);
      end
   endtask

   task automatic idle(input string tag);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask
   task automatic rd_tag(input int b, input string tag);
      step(0, 0, 0, 0, 1, 1, b, 0, 0, tag);
   endtask
   task automatic set_tag(input int b, input int v, input string tag);
      step(0, 0, 0, 0, 1, 0, b, v, 0, tag);
   endtask
   task automatic acc(input bit aw, input int unsigned aa, input int ak, input bit lap,
                      input string tag);
      step(1, aw, aa, ak, 0, 0, 0, 0, lap, tag);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mtbl[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if ({acc_done, acc_grant, acc_viol, op_done, op_rdata} !== '0) begin
         fails++;
         $display("FAIL R12 outputs in reset actual %b%b%b%b/%h expected 0000/00",
                  acc_done, acc_grant, acc_viol, op_done, op_rdata);
      end
      @(negedge clk);
      rst_n = 1'b1;
      idle("R12");
      rd_tag(5, "R12 tag zero after reset");

      set_tag(3, 5 << 3, "R8 write tag");
      rd_tag(3, "R9 read back");
      acc(1, 32'h1800, 5, 0, "R3 store matching key");
      rd_tag(3, "R6 store sets ref and chg");
      acc(1, 32'h1800, 6, 0, "R3 store wrong key");
      rd_tag(3, "R3 refused store unchanged");

      set_tag(3, 5 << 3, "R8 rewrite tag");
      acc(0, 32'h1804, 6, 0, "R4 fetch unprotected");
      rd_tag(3, "R6 fetch sets ref only");

      set_tag(4, (7 << 3) | 4, "R8 protected tag");
      acc(0, 32'h2000, 2, 0, "R4 protected fetch wrong key");
      rd_tag(4, "R6 violation no update");
      acc(0, 32'h2000, 7, 0, "R4 protected fetch matching key");
      rd_tag(4, "R6 protected fetch ref");
      acc(1, 32'h2000, 0, 0, "R5 master key store");
      rd_tag(4, "R6 master store chg");

      set_tag(3, 1 << 3, "R8 key one");
      acc(1, 32'h1FFF, 1, 0, "R1 last byte of block 3");
      acc(1, 32'h2000, 1, 0, "R1 first byte of block 4");
      rd_tag(3, "R1 block 3 updated");

      acc(1, 32'h0100, 0, 1, "R7 guarded store master key");
      acc(1, 32'h01FF, 0, 1, "R7 guarded store top of window");
      acc(1, 32'h0200, 0, 1, "R7 store just above window");
      acc(0, 32'h0010, 3, 1, "R7 fetch in window");
      acc(1, 32'h0100, 0, 0, "R7 guard off");
      rd_tag(0, "R7 block 0 flags");

      acc(1, 32'h200000, 0, 0, "R2 store beyond reach");
      acc(0, 32'hFFFFFF, 0, 0, "R2 fetch beyond reach");
      rd_tag(0, "R2 aliased block untouched");

      rd_tag(4, "R9 read tag");
      step(0, 0, 0, 0, 1, 2, 4, 0, 0, "R10 read and clear ref");
      rd_tag(4, "R10 ref cleared chg kept");
      step(0, 0, 0, 0, 1, 3, 4, 7'h7F, 0, "R9 reserved code no write");
      rd_tag(4, "R9 reserved left tag");

      step(1, 1, 32'h3000, 0, 1, 1, 6, 0, 0, "R11 collision");
      rd_tag(6, "R11 dropped access left tag");
      idle("R13 idle");

      for (int n = 0; n < 600; n++) begin
         int unsigned a = ($urandom % 16 == 0) ? 32'h200000 + ($urandom % 4096)
                                                : ($urandom % 8) * 2048 + ($urandom % 2048);
         bit ov = ($urandom % 4) == 0;
         bit av = ($urandom % 5) != 0;
         step(av, 1'($urandom), a, int'($urandom % 4), ov, int'($urandom % 4),
              int'($urandom % 8), int'($urandom % 128), 1'($urandom), "R6 random");
      end
      idle("R13");
      finish_run();
   end
endmodule